// File: doc/BRIEF.md
# Deferred Condition-Code Flag Evaluator

This block keeps a pending condition-code record instead of a flag word. An execution stage writes the kind of operation it just performed, the result it produced and the source operand it used, plus the current extend bit. No flag logic runs at that point. When a consumer needs the flags, it pulses a flush strobe. The block then works out negative, zero, overflow and carry from the stored record in a single clock. It registers the flag word and turns the record into "already resolved" form, so a later flush returns the same word.

The operation kinds are logical, add, subtract at three sizes (byte, word, long), extended add and extended subtract. The extended kinds use a carry rule that depends on the stored extend bit. They can also only clear the zero flag, never set it, so a multi-word chain of extended operations reports zero only when every word was zero. An unknown operation code flags an error and leaves the flag word alone.

Top module: `lazycc_flags`

## Requirements
- R1: Synchronous active-high reset clears the flag word to 0 and `err_o` to 0. The record is left in resolved mode, so `resolved_o` is 1.
- R2: The flag word packs C in bit 0, V in bit 1, Z in bit 2 and N in bit 3. For a logical record (op code 1): N is bit 31 of dest, Z is 1 when dest is zero, and V and C are 0.
- R3: For an add record (op code 2), dest is the sum and src the second addend. C is 1 when dest < src as unsigned numbers. V is 1 when the first addend (dest − src) and src have the same sign and dest's sign differs from it.
- R4: For a 32-bit subtract record (op code 3), dest is the difference and src the subtrahend, and the minuend is rebuilt as dest + src. C is 1 when the minuend < src as unsigned numbers. V is the top bit of (minuend XOR dest) AND (minuend XOR src).
- R5: Byte subtract (op code 4) and word subtract (op code 5) apply the R4 rules to only the low 8 or 16 bits of dest and src. N comes from bit 7 or bit 15, and Z looks at those low bits only.
- R6: For an extended add (op code 6) with the stored extend bit set, C is 1 when dest <= src, and the first addend is rebuilt as dest − src − 1 for V. With the extend bit clear, the R3 rules apply.
- R7: For an extended subtract (op code 7) with the stored extend bit set, the minuend is rebuilt as dest + src + 1 and C is 1 when that minuend <= src. With the extend bit clear, the R4 rules apply.
- R8: For op codes 6 and 7, the new Z is the Z of the current flag word AND (dest == 0). N, V and C follow R6 and R7.
- R9: A flush on a known op code updates `flags_o` on the next clock and sets `resolved_o`. The stored dest becomes the flag word, so a second flush returns the same flags.
- R10: A flush on an op code from 8 to 15 raises `err_o` for exactly one cycle and leaves `flags_o` unchanged. The record keeps its op code, so `resolved_o` stays 0.
- R11: When `rec_we` and `flush` are both high in the same cycle, the write takes effect and the flush is ignored: `flags_o` and `err_o` do not change.
- R12: Writing a record with op code 0 (resolved) makes `resolved_o` 1. A flush then returns bits 3..0 of the written dest as the flag word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rec_we | input | 1 | Record write strobe |
| rec_op | input | 4 | Operation code of the record |
| rec_dest | input | 32 | Result of the operation (or a flag word for op 0) |
| rec_src | input | 32 | Source operand of the operation |
| rec_x | input | 1 | Extend bit captured with the record |
| flush | input | 1 | Request to resolve the record into flags |
| flags_o | output | 4 | Resolved flag word {N,Z,V,C} |
| resolved_o | output | 1 | Record is in resolved mode |
| err_o | output | 1 | One-cycle pulse: flush hit an unknown op code |

## Verification
Directed records put the sign and carry boundaries of each kind on opposite sides: 0x7FFFFFFF and 0x80000000, dest equal to src, zero results. These cases separate a strict from a non-strict carry compare and an add-style from a subtract-style overflow rule. Byte and word subtracts use results that are zero or negative only in their low bits, which exposes a design that reads the flags at the wrong width. A chain of logical then extended records with zero and non-zero results tells a sticky zero apart from a plain one. Constrained random records that favour those corner values, checked against a bench model after every flush and again after a repeated flush, cover the rest of the op-code, data and extend-bit space.

// File: rtl/lazycc_pkg.sv
package lazycc_pkg;
  localparam int OP_W  = 4;
  localparam int FLG_W = 4;

  // flag word bit positions (consumers decode these)
  localparam int FB_C = 0;
  localparam int FB_V = 1;
  localparam int FB_Z = 2;
  localparam int FB_N = 3;

  // operation codes
  localparam logic [OP_W-1:0] OP_RESOLVED = 4'd0;
  localparam logic [OP_W-1:0] OP_LOGIC    = 4'd1;
  localparam logic [OP_W-1:0] OP_ADD      = 4'd2;
  localparam logic [OP_W-1:0] OP_SUB_L    = 4'd3;
  localparam logic [OP_W-1:0] OP_SUB_B    = 4'd4;
  localparam logic [OP_W-1:0] OP_SUB_W    = 4'd5;
  localparam logic [OP_W-1:0] OP_ADDX     = 4'd6;
  localparam logic [OP_W-1:0] OP_SUBX     = 4'd7;
  localparam logic [OP_W-1:0] OP_LAST     = OP_SUBX;

  localparam int NSUB = 3;  // byte, word, full-width subtract
endpackage

// File: rtl/lazycc_record.sv
module lazycc_record
  import lazycc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [OP_W-1:0]   w_op,
  input  logic [DATA_W-1:0] w_dest,
  input  logic [DATA_W-1:0] w_src,
  input  logic              w_x,
  input  logic              fold,
  input  logic [FLG_W-1:0]  fold_flags,
  output logic [OP_W-1:0]   op_q,
  output logic [DATA_W-1:0] dest_q,
  output logic [DATA_W-1:0] src_q,
  output logic              x_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_RESOLVED;
      dest_q <= '0;
      src_q  <= '0;
      x_q    <= 1'b0;
    end else if (we) begin
      op_q   <= w_op;
      dest_q <= w_dest;
      src_q  <= w_src;
      x_q    <= w_x;
    end else if (fold) begin
      // record collapses to resolved form holding its own flag word
      op_q   <= OP_RESOLVED;
      dest_q <= {{(DATA_W-FLG_W){1'b0}}, fold_flags};
    end
  end
endmodule

// File: rtl/lazycc_eval.sv
module lazycc_eval
  import lazycc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] dest,
  input  logic [DATA_W-1:0] src,
  input  logic              xin,
  input  logic              old_z,
  output logic [FLG_W-1:0]  flags,
  output logic              known
);
  localparam int                MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  // subtract flags at each size; last entry is the full data width
  logic [NSUB-1:0][FLG_W-1:0] sub_fl;

  for (genvar g = 0; g < NSUB; g++) begin : g_sub
    localparam int W = (g < NSUB-1) ? (BYTE_W << g) : DATA_W;
    logic [W-1:0] d_w, s_w, m_w, ov_w;
    assign d_w  = dest[W-1:0];
    assign s_w  = src[W-1:0];
    assign m_w  = d_w + s_w;
    assign ov_w = (m_w ^ d_w) & (m_w ^ s_w);
    assign sub_fl[g] = {d_w[W-1], (d_w == '0), ov_w[W-1], (m_w < s_w)};
  end

  // plain add
  logic [DATA_W-1:0] add_a;
  logic              add_c, add_v;
  assign add_a = dest - src;
  assign add_c = dest < src;
  assign add_v = (add_a[MSB] == src[MSB]) && (dest[MSB] != add_a[MSB]);

  // extended add with carry in
  logic [DATA_W-1:0] axx_a;
  logic              axx_c, axx_v;
  assign axx_a = dest - src - ONE;
  assign axx_c = dest <= src;
  assign axx_v = (axx_a[MSB] == src[MSB]) && (dest[MSB] != axx_a[MSB]);

  // extended subtract with borrow in
  logic [DATA_W-1:0] sxx_m, sxx_ov;
  logic              sxx_c;
  assign sxx_m  = dest + src + ONE;
  assign sxx_c  = sxx_m <= src;
  assign sxx_ov = (sxx_m ^ dest) & (sxx_m ^ src);

  logic n_l, z_l;
  assign n_l = dest[MSB];
  assign z_l = (dest == '0);

  always_comb begin
    flags = '0;
    known = 1'b1;
    case (op)
      OP_RESOLVED: flags = dest[FLG_W-1:0];
      OP_LOGIC:    flags = {n_l, z_l, 1'b0, 1'b0};
      OP_ADD:      flags = {n_l, z_l, add_v, add_c};
      OP_SUB_L:    flags = sub_fl[NSUB-1];
      OP_SUB_B:    flags = sub_fl[0];
      OP_SUB_W:    flags = sub_fl[1];
      OP_ADDX: begin
        if (xin) flags = {n_l, old_z & z_l, axx_v, axx_c};
        else     flags = {n_l, old_z & z_l, add_v, add_c};
      end
      OP_SUBX: begin
        if (xin) flags = {n_l, old_z & z_l, sxx_ov[MSB], sxx_c};
        else     flags = {n_l, old_z & z_l, sub_fl[NSUB-1][FB_V], sub_fl[NSUB-1][FB_C]};
      end
      default:     known = 1'b0;
    endcase
  end
endmodule

// File: rtl/lazycc_flags.sv
module lazycc_flags
  import lazycc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rec_we,
  input  logic [OP_W-1:0]   rec_op,
  input  logic [DATA_W-1:0] rec_dest,
  input  logic [DATA_W-1:0] rec_src,
  input  logic              rec_x,
  input  logic              flush,
  output logic [FLG_W-1:0]  flags_o,
  output logic              resolved_o,
  output logic              err_o
);
  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] dest_q, src_q;
  logic              x_q;
  logic [FLG_W-1:0]  eval_flags;
  logic              known;
  logic              flush_eff, fold;
  logic [FLG_W-1:0]  flags_q;
  logic              err_q;

  assign flush_eff = flush & ~rec_we;   // write wins over flush
  assign fold      = flush_eff & known;

  lazycc_record #(.DATA_W(DATA_W)) u_rec (
    .clk(clk), .rst(rst),
    .we(rec_we), .w_op(rec_op), .w_dest(rec_dest), .w_src(rec_src), .w_x(rec_x),
    .fold(fold), .fold_flags(eval_flags),
    .op_q(op_q), .dest_q(dest_q), .src_q(src_q), .x_q(x_q)
  );

  lazycc_eval #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_eval (
    .op(op_q), .dest(dest_q), .src(src_q), .xin(x_q), .old_z(flags_q[FB_Z]),
    .flags(eval_flags), .known(known)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (fold) flags_q <= eval_flags;
      err_q <= flush_eff & ~known;
    end
  end

  assign flags_o    = flags_q;
  assign err_o      = err_q;
  assign resolved_o = (op_q == OP_RESOLVED);

  // R9: a resolving flush publishes the evaluated word and resolved mode
  a_r9_resolve: assert property (@(posedge clk) disable iff (rst)
    (flush && !rec_we && known) |=> (resolved_o && flags_o == $past(eval_flags)));

  // R10: unknown op code flags an error and holds the word
  a_r10_unknown: assert property (@(posedge clk) disable iff (rst)
    (flush && !rec_we && !known) |=> (err_o && $stable(flags_o) && !resolved_o));

  // R10: error pulse only ever follows an accepted flush
  a_r10_err_cause: assert property (@(posedge clk) disable iff (rst)
    err_o |-> ($past(flush) && !$past(rec_we)));

  // R11: without an accepted flush the word does not move
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !(flush && !rec_we) |=> $stable(flags_o));

  // R12: a write sets resolved mode exactly when op code 0 is written
  a_r12_write_mode: assert property (@(posedge clk) disable iff (rst)
    rec_we |=> (resolved_o == ($past(rec_op) == OP_RESOLVED)));

  // R8: extended ops never raise Z
  a_r8_sticky_z: assert property (@(posedge clk) disable iff (rst)
    ((op_q == OP_ADDX || op_q == OP_SUBX) && !flags_o[FB_Z]) |-> !eval_flags[FB_Z]);
endmodule

// File: tb/lazycc_flags_bench.sv
module lazycc_flags_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rec_we = 1'b0;
  logic [3:0]  rec_op = '0;
  logic [31:0] rec_dest = '0;
  logic [31:0] rec_src = '0;
  logic        rec_x = 1'b0;
  logic        flush = 1'b0;
  logic [3:0]  flags_o;
  logic        resolved_o;
  logic        err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [3:0] mdl = 4'h0;

  always #2 clk = ~clk;

  lazycc_flags u_lazycc_flags (
    .clk(clk), .rst(rst), .rec_we(rec_we), .rec_op(rec_op), .rec_dest(rec_dest),
    .rec_src(rec_src), .rec_x(rec_x), .flush(flush),
    .flags_o(flags_o), .resolved_o(resolved_o), .err_o(err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference flag model, written from the requirements
  function automatic logic [3:0] model(input logic [3:0] op, input logic [31:0] d,
                                       input logic [31:0] s, input logic x, input logic oz);
    logic n, z, v, c;
    logic [31:0] msk, m, a, t;
    int w;
    n = d[31]; z = (d == 0); v = 0; c = 0;
    case (op)
      4'd0: return d[3:0];
      4'd1: ;
      4'd2: begin
        a = d - s; c = d < s;
        t = ~(a ^ s) & (d ^ a); v = t[31];
      end
      4'd3, 4'd4, 4'd5: begin
        w = (op == 4'd4) ? 8 : (op == 4'd5) ? 16 : 32;
        msk = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        m = (d + s) & msk;
        c = m < (s & msk);
        t = ((m ^ d) & (m ^ s)) >> (w - 1); v = t[0];
        t = d >> (w - 1); n = t[0];
        z = ((d & msk) == 0);
      end
      4'd6: begin
        if (x) begin a = d - s - 1; c = d <= s; end
        else   begin a = d - s;     c = d < s;  end
        t = ~(a ^ s) & (d ^ a); v = t[31];
        z = oz & z;
      end
      4'd7: begin
        if (x) begin m = d + s + 1; c = m <= s; end
        else   begin m = d + s;     c = m < s;  end
        t = (m ^ d) & (m ^ s); v = t[31];
        z = oz & z;
      end
      default: return 4'hx;
    endcase
    return {n, z, v, c};
  endfunction

  task automatic put(input logic [3:0] op, input logic [31:0] d, input logic [31:0] s, input logic x);
    @(negedge clk);
    rec_we = 1; rec_op = op; rec_dest = d; rec_src = s; rec_x = x;
    @(negedge clk);
    rec_we = 0;
  endtask

  // flush the record last written and compare against the model
  task automatic flush_chk(input string req, input logic [3:0] op, input logic [31:0] d,
                           input logic [31:0] s, input logic x);
    logic [3:0] e;
    e = model(op, d, s, x, mdl[2]);
    flush = 1;
    @(negedge clk);
    flush = 0;
    check(req, {28'd0, flags_o}, {28'd0, e});
    check(req, {31'd0, resolved_o}, 32'd1);
    mdl = e;
  endtask

  task automatic run(input string req, input logic [3:0] op, input logic [31:0] d,
                     input logic [31:0] s, input logic x);
    put(op, d, s, x);
    flush_chk(req, op, d, s, x);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 7)
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      4: return {$urandom} & 32'hFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED_C0DE));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 flags", {28'd0, flags_o}, 32'd0);
    check("R1 resolved", {31'd0, resolved_o}, 32'd1);
    check("R1 err", {31'd0, err_o}, 32'd0);

    // R2 logic
    run("R2 logic zero", 4'd1, 32'h0, 32'h1234, 0);
    check("R2 logic zero word", {28'd0, flags_o}, 32'h4);
    run("R2 logic neg", 4'd1, 32'h8000_0000, 32'h0, 0);
    check("R2 logic neg word", {28'd0, flags_o}, 32'h8);

    // R3 add
    run("R3 add carry", 4'd2, 32'h1, 32'h2, 0);
    check("R3 add carry word", {28'd0, flags_o}, 32'h1);
    run("R3 add ovf", 4'd2, 32'h8000_0000, 32'h1, 0);
    check("R3 add ovf word", {28'd0, flags_o}, 32'hA);

    // R4 subtract long
    run("R4 sub borrow", 4'd3, 32'hFFFF_FFFF, 32'h1, 0);
    check("R4 sub borrow word", {28'd0, flags_o}, 32'h9);
    run("R4 sub ovf", 4'd3, 32'h7FFF_FFFF, 32'h1, 0);
    check("R4 sub ovf word", {28'd0, flags_o}, 32'h2);

    // R5 byte and word subtract
    run("R5 byte zero", 4'd4, 32'hFFFF_FF00, 32'h12, 0);
    check("R5 byte zero word", {28'd0, flags_o}, 32'h4);
    run("R5 word neg", 4'd5, 32'h0000_8000, 32'h1, 0);
    check("R5 word neg word", {28'd0, flags_o}, 32'h8);
    run("R5 word ovf", 4'd5, 32'h0000_7FFF, 32'h1, 0);
    check("R5 word ovf word", {28'd0, flags_o}, 32'h2);

    // R6 extended add, equal operands separate the compares
    run("R6 addx x", 4'd6, 32'h5, 32'h5, 1);
    check("R6 addx x carry", {31'd0, flags_o[0]}, 32'd1);
    run("R6 addx nox", 4'd6, 32'h5, 32'h5, 0);
    check("R6 addx nox carry", {31'd0, flags_o[0]}, 32'd0);

    // R7 extended subtract
    run("R7 subx x", 4'd7, 32'hFFFF_FFFF, 32'h0, 1);
    check("R7 subx x carry", {31'd0, flags_o[0]}, 32'd1);
    run("R7 subx nox", 4'd7, 32'hFFFF_FFFF, 32'h0, 0);
    check("R7 subx nox carry", {31'd0, flags_o[0]}, 32'd0);

    // R8 sticky zero chain
    run("R8 seed z", 4'd1, 32'h0, 32'h0, 0);
    run("R8 addx keeps z", 4'd6, 32'h0, 32'h0, 0);
    check("R8 z kept", {31'd0, flags_o[2]}, 32'd1);
    run("R8 clear z", 4'd1, 32'h1, 32'h0, 0);
    run("R8 subx no set", 4'd7, 32'h0, 32'h0, 0);
    check("R8 z not set", {31'd0, flags_o[2]}, 32'd0);

    // R9 repeated flush returns the same word
    run("R9 first", 4'd2, 32'h8000_0000, 32'h1, 0);
    flush_chk("R9 second flush", 4'd0, {28'd0, mdl}, 32'h0, 0);

    // R10 unknown op
    put(4'd9, 32'h0, 32'h0, 0);
    check("R10 not resolved", {31'd0, resolved_o}, 32'd0);
    flush = 1;
    @(negedge clk);
    flush = 0;
    check("R10 err", {31'd0, err_o}, 32'd1);
    check("R10 flags held", {28'd0, flags_o}, {28'd0, mdl});
    check("R10 still pending", {31'd0, resolved_o}, 32'd0);
    @(negedge clk);
    check("R10 err one cycle", {31'd0, err_o}, 32'd0);

    // R11 write wins over simultaneous flush
    put(4'd1, 32'h0, 32'h0, 0);
    rec_we = 1; rec_op = 4'd3; rec_dest = 32'h8000_0000; rec_src = 32'h1; flush = 1;
    @(negedge clk);
    rec_we = 0; flush = 0;
    check("R11 flags held", {28'd0, flags_o}, {28'd0, mdl});
    check("R11 pending", {31'd0, resolved_o}, 32'd0);
    check("R11 no err", {31'd0, err_o}, 32'd0);
    flush_chk("R11 new record used", 4'd3, 32'h8000_0000, 32'h1, 0);

    // R12 resolved record written directly
    put(4'd0, 32'hFFFF_FFFA, 32'h0, 0);
    check("R12 resolved on write", {31'd0, resolved_o}, 32'd1);
    flush_chk("R12 flag word", 4'd0, 32'hFFFF_FFFA, 32'h0, 0);
    check("R12 flag word value", {28'd0, flags_o}, 32'hA);

    // constrained random records, R2..R9
    for (int i = 0; i < 400; i++) begin
      logic [3:0] op;
      logic [31:0] d, s;
      logic x;
      op = 4'(1 + ($urandom % 7));
      d = pick();
      s = ($urandom % 4 == 0) ? d : pick();
      x = 1'($urandom);
      put(op, d, s, x);
      check("R9 pending before flush", {31'd0, resolved_o}, 32'd0);
      flush_chk("R2-7 random", op, d, s, x);
      if (i % 8 == 0) flush_chk("R9 random reflush", 4'd0, {28'd0, mdl}, 32'h0, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule